// File: doc/BRIEF.md
# SPI Register Access Slave

This block is a serial slave that lets an external controller read and write a small bank of byte-wide registers over a four-wire SPI link. The link runs in mode 0: the clock idles low, input bits are taken on the rising SCK edge and output bits change on the falling edge. Chip select is active low. The block samples SCK, chip select and the data input with its own system clock. Every event is therefore a single-cycle strobe in that clock domain.

Each byte that arrives after chip select falls is either a command or write data. A command names a 5-bit register address and says whether it is a read or a write. While the controller clocks in one byte, the block shifts out the register that the previous command named. A read is therefore answered during the byte that follows it, and that byte can itself be the next command. A write needs a second byte, the data. The data is held until chip select rises and is kept only if the write ended exactly on its sixteenth bit. Low addresses are read/write control registers, which appear on a parallel output bus. A window of higher addresses maps read-only status bytes from a parallel input bus. Each completed read command raises a one-cycle strobe carrying the address, so the status logic can clear what was read.

Top module: `spi_reg_slave`

## Requirements
- R1: While reset is asserted, and on the first clock after it, every control register reads zero, the data output enable is low and the read strobe is low.
- R2: A command byte is received MSB first on rising SCK edges. Bit 7 set means a write and bit 7 clear means a read. Bits 4..0 give the address. Bits 6 and 5 have no effect.
- R3: On the falling SCK edge that follows the eighth bit of a command, the output shifter loads the addressed register. The next byte shifts that value out MSB first, and the output changes only on falling SCK edges or when chip select falls.
- R4: The byte shifted out during any byte slot holds the contents of the most recently received address, even if that address arrived in an earlier chip-select period.
- R5: Until the first command after reset, the bytes shifted out are all zeros.
- R6: Chip select may stay low across a chain of read commands. Each byte received while read data goes out is decoded as the next command.
- R7: Write data reaches a control register only on the clock where chip select returns high. The control output does not change while chip select is low.
- R8: A write is kept only if chip select rises right after the sixteenth bit counted from the start of its command byte. A shorter or longer transfer drops it, but read commands earlier in the same chip-select period still return their data.
- R9: A write to a status address (16 up to 16 plus the number of status bytes) or to an unmapped address changes no control register. Unmapped addresses read as zero.
- R10: Each completed read command produces a read strobe exactly one clock long, with the read address on its address output, on the clock after the falling SCK edge that loads the data.
- R11: The data output enable rises one clock after chip select falls and drops one clock after it rises. The first output bit is valid from that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, idles low |
| csb | input | 1 | Chip select, active low |
| di | input | 1 | Serial data from the controller |
| do_o | output | 1 | Serial data to the controller |
| do_oe | output | 1 | Output enable for the serial data pin |
| status_in | input | N_STAT*8 | Read-only status bytes, byte i at address STAT_BASE+i |
| ctrl_out | output | N_CTRL*8 | Control register contents, byte i at address i |
| rd_strobe | output | 1 | One-cycle pulse per completed read command |
| rd_addr | output | 5 | Address of the read that caused the strobe |

## Verification
All outputs are registered. Each serial-side result appears one clock after the system-clock edge that sees its SCK or chip-select transition. The shifted byte is loaded one clock after the falling SCK edge that ends a command. The strobe comes one clock after that same falling edge. A committed write shows on the control bus one clock after chip select is seen high. The bench drives pins on the falling system-clock edge and compares every output against its behavioural model on the next falling edge, which is one full register stage after the rising edge that acted on the inputs. The serial bytes captured at the pins are also compared against fixed expected values derived from the requirements.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int WR_BIT = BYTE_W - 1;

  function automatic logic cmd_is_write(input logic [BYTE_W-1:0] b);
    return b[WR_BIT];
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [BYTE_W-1:0] b);
    return b[ADDR_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] shift_out(input logic [BYTE_W-1:0] b);
    return {b[BYTE_W-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/spi_edge_detect.sv
module spi_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic csb,
  output logic sck_rise,
  output logic sck_fall,
  output logic csb_fall,
  output logic csb_rise
);
  logic sck_q;
  logic csb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      csb_q <= 1'b1;
    end else begin
      sck_q <= sck;
      csb_q <= csb;
    end
  end

  assign csb_fall = csb_q & ~csb;
  assign csb_rise = ~csb_q & csb;
  assign sck_rise = ~csb & sck & ~sck_q;
  assign sck_fall = ~csb & ~sck & sck_q;
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              di,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              csb_fall,
  input  logic              csb_rise,
  output logic [ADDR_W-1:0] last_addr,
  output logic              addr_valid,
  output logic              load_evt,
  output logic              commit_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_strobe,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] rx_next;
  logic [CNT_W-1:0]  bit_cnt;
  logic              byte_end;
  logic              expect_data;
  logic              pend_wr;
  logic              load_pend;
  logic              rd_pend;

  assign rx_next    = {rx_q, di};
  assign byte_end   = sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
  assign load_evt   = sck_fall && load_pend;
  assign commit_evt = csb_rise && pend_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q        <= '0;
      bit_cnt     <= '0;
      expect_data <= 1'b0;
      pend_wr     <= 1'b0;
      load_pend   <= 1'b0;
      rd_pend     <= 1'b0;
      last_addr   <= '0;
      addr_valid  <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      rd_strobe   <= 1'b0;
      rd_addr     <= '0;
    end else begin
      rd_strobe <= 1'b0;
      if (csb_fall) begin
        bit_cnt     <= '0;
        expect_data <= 1'b0;
        pend_wr     <= 1'b0;
        load_pend   <= 1'b0;
        rd_pend     <= 1'b0;
      end else if (csb_rise) begin
        pend_wr <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_q    <= rx_next[BYTE_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          pend_wr <= 1'b0;
        end
        if (byte_end) begin
          load_pend <= 1'b1;
          if (expect_data) begin
            wr_data     <= rx_next;
            pend_wr     <= 1'b1;
            expect_data <= 1'b0;
          end else begin
            last_addr  <= cmd_addr(rx_next);
            addr_valid <= 1'b1;
            if (cmd_is_write(rx_next)) begin
              expect_data <= 1'b1;
              wr_addr     <= cmd_addr(rx_next);
            end else begin
              rd_pend <= 1'b1;
            end
          end
        end
        if (load_evt) begin
          load_pend <= 1'b0;
          if (rd_pend) begin
            rd_strobe <= 1'b1;
            rd_addr   <= last_addr;
            rd_pend   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb_fall,
  input  logic              csb_rise,
  input  logic              sck_fall,
  input  logic              load_evt,
  input  logic [BYTE_W-1:0] load_data,
  output logic              do_o,
  output logic              do_oe
);
  logic [BYTE_W-1:0] tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q  <= '0;
      do_oe <= 1'b0;
    end else if (csb_fall) begin
      tx_q  <= load_data;
      do_oe <= 1'b1;
    end else if (csb_rise) begin
      do_oe <= 1'b0;
    end else if (load_evt) begin
      tx_q <= load_data;
    end else if (sck_fall) begin
      tx_q <= shift_out(tx_q);
    end
  end

  assign do_o = tx_q[BYTE_W-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int N_CTRL    = 8,
  parameter int STAT_BASE = 16,
  parameter int N_STAT    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [BYTE_W-1:0]        rd_data,
  input  logic [N_STAT*BYTE_W-1:0] status_in,
  output logic [N_CTRL*BYTE_W-1:0] ctrl_out
);
  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    logic [BYTE_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
        r_q <= wr_data;
      end
    end
    assign ctrl_out[g*BYTE_W +: BYTE_W] = r_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_CTRL; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = ctrl_out[i*BYTE_W +: BYTE_W];
    end
    for (int j = 0; j < N_STAT; j++) begin
      if (rd_addr == ADDR_W'(STAT_BASE + j)) rd_data = status_in[j*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int N_CTRL    = 8,
  parameter int STAT_BASE = 16,
  parameter int N_STAT    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck,
  input  logic                     csb,
  input  logic                     di,
  output logic                     do_o,
  output logic                     do_oe,
  input  logic [N_STAT*BYTE_W-1:0] status_in,
  output logic [N_CTRL*BYTE_W-1:0] ctrl_out,
  output logic                     rd_strobe,
  output logic [ADDR_W-1:0]        rd_addr
);
  logic              sck_rise_evt;
  logic              sck_fall_evt;
  logic              csb_fall_evt;
  logic              csb_rise_evt;
  logic              load_evt;
  logic              commit_evt;
  logic [ADDR_W-1:0] last_addr;
  logic              addr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] bank_rdata;
  logic [BYTE_W-1:0] load_data;

  spi_edge_detect u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .csb      (csb),
    .sck_rise (sck_rise_evt),
    .sck_fall (sck_fall_evt),
    .csb_fall (csb_fall_evt),
    .csb_rise (csb_rise_evt)
  );

  spi_frame_ctrl u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .di         (di),
    .sck_rise   (sck_rise_evt),
    .sck_fall   (sck_fall_evt),
    .csb_fall   (csb_fall_evt),
    .csb_rise   (csb_rise_evt),
    .last_addr  (last_addr),
    .addr_valid (addr_valid),
    .load_evt   (load_evt),
    .commit_evt (commit_evt),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_strobe  (rd_strobe),
    .rd_addr    (rd_addr)
  );

  spi_reg_bank #(
    .N_CTRL    (N_CTRL),
    .STAT_BASE (STAT_BASE),
    .N_STAT    (N_STAT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (commit_evt),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (last_addr),
    .rd_data   (bank_rdata),
    .status_in (status_in),
    .ctrl_out  (ctrl_out)
  );

  assign load_data = addr_valid ? bank_rdata : '0;

  spi_tx_shift u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .csb_fall  (csb_fall_evt),
    .csb_rise  (csb_rise_evt),
    .sck_fall  (sck_fall_evt),
    .load_evt  (load_evt),
    .load_data (load_data),
    .do_o      (do_o),
    .do_oe     (do_oe)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csb,
  input logic          do_o,
  input logic          do_oe,
  input logic          rd_strobe,
  input logic [CW-1:0] ctrl_out,
  input logic          sck_fall_evt,
  input logic          csb_fall_evt,
  input logic          commit_evt
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (ctrl_out == '0 && !do_oe && !rd_strobe));

  a_r3_do_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(do_o) |-> $past(sck_fall_evt || csb_fall_evt));

  a_r7_ctrl_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_out) |-> $past(commit_evt));

  a_r10_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rd_strobe);

  a_r10_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> $past(sck_fall_evt));

  a_r11_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csb) |=> do_oe);

  a_r11_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    csb |=> !do_oe);
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.CW(N_CTRL * spi_reg_pkg::BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csb          (csb),
  .do_o         (do_o),
  .do_oe        (do_oe),
  .rd_strobe    (rd_strobe),
  .ctrl_out     (ctrl_out),
  .sck_fall_evt (sck_fall_evt),
  .csb_fall_evt (csb_fall_evt),
  .commit_evt   (commit_evt)
);

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        csb = 1'b1;
  logic        di = 1'b0;
  logic        do_o;
  logic        do_oe;
  logic [31:0] status_in = 32'h4433_9911;
  logic [63:0] ctrl_out;
  logic        rd_strobe;
  logic [4:0]  rd_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int strobe_cnt_11 = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_reg_slave u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .di(di),
    .do_o(do_o), .do_oe(do_oe), .status_in(status_in), .ctrl_out(ctrl_out),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr)
  );

  // Behavioural reference model
  int m_ctrl[8];
  int m_ps, m_pc, m_bits, m_rx, m_last, m_mode, m_waddr, m_wdata, m_wlen;
  int m_tx, m_oe, m_stb, m_saddr, m_loadp, m_rdp;

  function automatic int m_read(input int a);
    if (a < 0) return 0;
    if (a < 8) return m_ctrl[a];
    if (a >= 16 && a < 20) return int'(status_in[(a - 16) * 8 +: 8]);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_ctrl[k]) m_ctrl[k] = 0;
      m_ps = 0; m_pc = 1; m_bits = 0; m_rx = 0; m_last = -1; m_mode = 0;
      m_waddr = 0; m_wdata = 0; m_wlen = -1; m_tx = 0; m_oe = 0;
      m_stb = 0; m_saddr = 0; m_loadp = 0; m_rdp = 0;
    end else begin
      m_stb = 0;
      if (m_pc == 1 && csb == 1'b0) begin
        m_tx = m_read(m_last); m_oe = 1; m_bits = 0; m_mode = 0;
        m_wlen = -1; m_loadp = 0; m_rdp = 0;
      end else if (m_pc == 0 && csb == 1'b1) begin
        m_oe = 0;
        if (m_wlen == 16 && m_waddr < 8) m_ctrl[m_waddr] = m_wdata;
        m_wlen = -1;
      end else if (csb == 1'b0) begin
        if (sck == 1'b1 && m_ps == 0) begin
          m_rx = ((m_rx << 1) | int'(di)) & 255;
          m_bits++;
          if (m_wlen >= 0) m_wlen++;
          if (m_bits == 8) begin
            m_bits = 0; m_loadp = 1;
            if (m_mode == 1) begin
              m_wdata = m_rx; m_mode = 0;
            end else begin
              m_last = m_rx % 32;
              if (m_rx >= 128) begin m_mode = 1; m_waddr = m_last; m_wlen = 8; end
              else m_rdp = 1;
            end
          end
        end
        if (sck == 1'b0 && m_ps == 1) begin
          if (m_loadp == 1) begin
            m_tx = m_read(m_last); m_loadp = 0;
            if (m_rdp == 1) begin m_stb = 1; m_saddr = m_last; m_rdp = 0; end
          end else begin
            m_tx = (m_tx << 1) & 255;
          end
        end
      end
      m_ps = int'(sck); m_pc = int'(csb);
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(do_oe) != m_oe) begin
        errors++; $display("FAIL R11 do_oe act=%0d exp=%0d t=%0t", do_oe, m_oe, $time);
      end
      if (do_oe && int'(do_o) != (m_tx >> 7)) begin
        errors++; $display("FAIL R3 do_o act=%0d exp=%0d t=%0t", do_o, m_tx >> 7, $time);
      end
      if (int'(rd_strobe) != m_stb || (m_stb == 1 && int'(rd_addr) != m_saddr)) begin
        errors++; $display("FAIL R10 strobe act=%0d/%0d exp=%0d/%0d t=%0t",
                           rd_strobe, rd_addr, m_stb, m_saddr, $time);
      end
      for (int k = 0; k < 8; k++) begin
        if (int'(ctrl_out[k*8 +: 8]) != m_ctrl[k]) begin
          errors++; $display("FAIL R7 ctrl%0d act=%h exp=%h t=%0t", k, ctrl_out[k*8 +: 8], m_ctrl[k], $time);
        end
      end
      if (rd_strobe && rd_addr == 5'h11) strobe_cnt_11++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk); csb = 1'b0; wait_n(2);
  endtask

  task automatic cs_high();
    @(negedge clk); csb = 1'b1; wait_n(3);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); sck = 1'b0; di = v[i];
      wait_n(2);
      r[i] = do_o;
      sck = 1'b1;
      wait_n(1);
    end
    @(negedge clk); sck = 1'b0;
    wait_n(1);
  endtask

  task automatic xfer(input logic [7:0] v, output logic [7:0] r);
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; di = v[i];
      wait_n(2);
      r[i] = do_o;
      sck = 1'b1;
      wait_n(1);
    end
  endtask

  task automatic end_bytes();
    @(negedge clk); sck = 1'b0; wait_n(2);
  endtask

  task automatic expect8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    logic [7:0] r0, r1, r2;
    wait_n(4);
    // R1: reset state at the pins
    expect8("R1 ctrl_low", ctrl_out[7:0], 8'h00);
    expect8("R1 do_oe", {7'd0, do_oe}, 8'h00);
    expect8("R1 rd_strobe", {7'd0, rd_strobe}, 8'h00);
    rst_n = 1'b1;
    wait_n(3);

    // R5: first byte after reset is zero; R3 read of ctrl3
    cs_low();
    expect8("R11 oe_high", {7'd0, do_oe}, 8'h01);
    xfer(8'h03, r0); xfer(8'h00, r1); end_bytes(); cs_high();
    expect8("R5 first_byte", r0, 8'h00);
    expect8("R3 ctrl3_read", r1, 8'h00);
    expect8("R11 oe_low", {7'd0, do_oe}, 8'h00);

    // R7: write ctrl2, no change until CSB rises
    cs_low(); xfer(8'h82, r0); xfer(8'hA5, r1); end_bytes();
    expect8("R7 before_release", ctrl_out[23:16], 8'h00);
    cs_high();
    expect8("R7 after_release", ctrl_out[23:16], 8'hA5);

    // R2: bits 6..5 ignored; R4: first byte shows last address of prior frame
    cs_low(); xfer(8'hE1, r0); xfer(8'h3C, r1); end_bytes(); cs_high();
    expect8("R4 prior_frame", r0, 8'hA5);
    expect8("R2 ignored_bits", ctrl_out[15:8], 8'h3C);

    // R6: chained reads with CSB held low
    cs_low(); xfer(8'h02, r0); xfer(8'h01, r1); xfer(8'h00, r2); end_bytes(); cs_high();
    expect8("R4 chain_first", r0, 8'h3C);
    expect8("R6 chain_second", r1, 8'hA5);
    expect8("R6 chain_third", r2, 8'h3C);

    // R8: short write dropped
    cs_low(); xfer(8'h85, r0); send_bits(8'hF0, 4, r1); cs_high();
    expect8("R8 short_write", ctrl_out[47:40], 8'h00);

    // R8: long write dropped
    cs_low(); xfer(8'h85, r0); xfer(8'h77, r1); send_bits(8'h80, 1, r2); cs_high();
    expect8("R8 long_write", ctrl_out[47:40], 8'h00);

    // R8: read before write in the same frame; write still kept
    cs_low(); xfer(8'h01, r0); xfer(8'h86, r1); xfer(8'h5A, r2); end_bytes(); cs_high();
    expect8("R8 prior_read", r1, 8'h3C);
    expect8("R8 write_kept", ctrl_out[55:48], 8'h5A);

    // R10: status read and strobe
    cs_low(); xfer(8'h11, r0); xfer(8'h00, r1); end_bytes(); cs_high();
    expect8("R10 status_read", r1, 8'h99);
    expect8("R10 strobe_count", 8'(strobe_cnt_11), 8'h01);

    // R9: writes to status and unmapped addresses
    cs_low(); xfer(8'h91, r0); xfer(8'hFF, r1); end_bytes(); cs_high();
    cs_low(); xfer(8'h8A, r0); xfer(8'hEE, r1); end_bytes(); cs_high();
    cs_low(); xfer(8'h0A, r0); xfer(8'h11, r1); xfer(8'h00, r2); end_bytes(); cs_high();
    expect8("R9 unmapped_read", r1, 8'h00);
    expect8("R9 status_read", r2, 8'h99);
    expect8("R9 ctrl_untouched", 8'(ctrl_out == 64'h005A_0000_00A5_3C00), 8'h01);

    wait_n(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule